// File: doc/BRIEF.md
# Fractional Double-Length Multiplier

This block multiplies two signed binary fractions of one word each. A word is a sign bit followed by fraction bits, so it spans -1 up to just under +1. The block works sequentially: it takes one multiplier bit per cycle with a shift-and-add step, then makes a sign correction and formats the result. A caller presents a multiplicand, a multiplier and a mode bit on a valid/ready request port. The result comes back on a valid/ready response port.

In the double-length mode, the full product appears across two words. The accumulator word holds the sign and the upper product bits. The auxiliary word holds the lower product bits and always has a zero sign bit. In the rounded mode, the accumulator word holds the product rounded to one word and the auxiliary word is zero. Only one product cannot be represented: minus one times minus one, which equals +1. That case saturates to the largest positive value and raises the overflow flag.

The request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. The response holds `rsp_valid`, `rsp_a`, `rsp_r` and `rsp_ovf` steady until `rsp_ready` is seen high. If `rsp_ready` is tied high, `rsp_valid` is a one-cycle done pulse.

Top module: `fmul_frac`

## Requirements
- R1: `req_ready` is 1 only while idle. Operands and mode are sampled on the accepting edge. Changes on `req_valid`, `req_round`, `req_a` or `req_b` while busy have no effect on the result in flight.
- R2: `rsp_valid` rises exactly W clock edges after the accepting edge (W-1 step cycles plus one finishing cycle; 20 with defaults).
- R3: With `req_round` = 0, let P be the two's complement product of `req_a` and `req_b` (2W bits, 2W-2 fraction bits). Then `rsp_a` equals P[2W-2:W-1] and `rsp_r[W-2:0]` equals P[W-2:0].
- R4: With `req_round` = 0, `rsp_r[W-1]` (the sign bit of the low word) is always 0.
- R5: `rsp_ovf` is 1 only when both operands are the most negative word (sign bit 1, rest 0). In that case `rsp_a` is the largest positive word (0 then all ones). `rsp_r` is also all-ones-below-the-sign in mode 0, and zero in mode 1.
- R6: With `req_round` = 1, `rsp_a` equals bits [2W-2:W-1] of P + 2^(W-2), which rounds half upward. `rsp_r` is zero.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_a`, `rsp_r` and `rsp_ovf` stay unchanged. After the edge where both are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R8: After reset, `req_ready` is 1 and `rsp_valid`, `rsp_a`, `rsp_r` and `rsp_ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request presents operands |
| req_ready | output | 1 | Block idle, request can be taken |
| req_round | input | 1 | 0: double-length product, 1: rounded single length |
| req_a | input | W | Multiplicand fraction |
| req_b | input | W | Multiplier fraction |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_a | output | W | Upper or rounded product word |
| rsp_r | output | W | Lower product word, or zero when rounded |
| rsp_ovf | output | 1 | Product was +1 and saturated |

## Verification
The bound checker watches the following on every cycle:
- the busy/idle handshake;
- the exact W-edge latency, using its own counter;
- the cleared sign bit of the low word;
- the cleared low word in the rounded mode;
- that overflow occurs only for the two-minus-ones operand pair, and always with a saturated high word;
- stability under back-pressure.

The actual product bits, including rounding at exactly half an LSB and on either side of it for both signs, can only be shown by the bench's vectors. The same holds for the reset values and for inputs ignored during a run.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_HOLD = 2'd3
  } fmul_state_e;

endpackage

// File: rtl/fmul_ctrl.sv
module fmul_ctrl #(
  parameter int W = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic load,
  output logic step,
  output logic finish,
  output logic rsp_valid
);
  import fmul_pkg::*;

  localparam int FW = W - 1;
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] LAST = CW'(FW - 1);

  fmul_state_e   state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_HOLD;
        ST_HOLD: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign load      = (state == ST_IDLE) && req_valid;
  assign step      = (state == ST_RUN);
  assign finish    = (state == ST_FIN);
  assign rsp_valid = (state == ST_HOLD);

endmodule

// File: rtl/fmul_core.sv
module fmul_core #(
  parameter int W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [W-1:0]    mcand_in,
  input  logic [W-1:0]    mplier_in,
  output logic [2*W-1:0]  prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] acc;
  logic [PW-1:0] mcand;
  logic [W-1:0]  mplier;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
    end else if (load) begin
      acc    <= '0;
      mcand  <= {{W{mcand_in[W-1]}}, mcand_in};
      mplier <= mplier_in;
    end else if (step) begin
      if (mplier[0]) acc <= acc + mcand;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
    end
  end

  // After all fraction bits are consumed, mplier[0] is the sign bit and
  // mcand carries the multiplicand at the sign's negative weight.
  assign prod = mplier[0] ? (acc - mcand) : acc;

endmodule

// File: rtl/fmul_pack.sv
module fmul_pack #(
  parameter int W = 20
) (
  input  logic [2*W-1:0] prod,
  input  logic           round,
  output logic [W-1:0]   hi_o,
  output logic [W-1:0]   lo_o,
  output logic           ovf_o
);
  localparam int PW = 2 * W;
  localparam int FW = W - 1;
  localparam logic [PW-1:0] HALF = PW'(1) << (FW - 1);
  localparam logic [W-1:0]  MAXW = {1'b0, {FW{1'b1}}};

  logic [PW-1:0] q;
  logic          sat;

  always_comb begin
    q     = round ? (prod + HALF) : prod;
    sat   = (q[PW-1:PW-2] == 2'b01);
    ovf_o = sat;
    hi_o  = sat ? MAXW : q[2*FW:FW];
    if (round)    lo_o = '0;
    else if (sat) lo_o = MAXW;
    else          lo_o = {1'b0, q[FW-1:0]};
  end

endmodule

// File: rtl/fmul_frac.sv
module fmul_frac #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_round,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_a,
  output logic [W-1:0] rsp_r,
  output logic         rsp_ovf
);
  localparam int PW = 2 * W;

  logic          load, step, finish;
  logic          mode_q;
  logic [PW-1:0] prod;
  logic [W-1:0]  hi_w, lo_w;
  logic          ovf_w;

  fmul_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_ready (rsp_ready),
    .req_ready (req_ready),
    .load      (load),
    .step      (step),
    .finish    (finish),
    .rsp_valid (rsp_valid)
  );

  fmul_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .mcand_in  (req_a),
    .mplier_in (req_b),
    .prod      (prod)
  );

  fmul_pack #(.W(W)) u_pack (
    .prod  (prod),
    .round (mode_q),
    .hi_o  (hi_w),
    .lo_o  (lo_w),
    .ovf_o (ovf_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      rsp_a   <= '0;
      rsp_r   <= '0;
      rsp_ovf <= 1'b0;
    end else begin
      if (load) mode_q <= req_round;
      if (finish) begin
        rsp_a   <= hi_w;
        rsp_r   <= lo_w;
        rsp_ovf <= ovf_w;
      end
    end
  end

endmodule

// File: rtl/fmul_frac_chk.sv
module fmul_frac_chk #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic         req_round,
  input logic [W-1:0] req_a,
  input logic [W-1:0] req_b,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_a,
  input logic [W-1:0] rsp_r,
  input logic         rsp_ovf
);
  localparam int LCW = $clog2(W + 2) + 1;
  localparam logic [LCW-1:0] LAT = LCW'(W);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  logic           c_round;
  logic [W-1:0]   c_a, c_b;
  logic [LCW-1:0] lat;
  logic           active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_round <= 1'b0;
      c_a     <= '0;
      c_b     <= '0;
      lat     <= '0;
      active  <= 1'b0;
    end else if (req_valid && req_ready) begin
      c_round <= req_round;
      c_a     <= req_a;
      c_b     <= req_b;
      lat     <= '0;
      active  <= 1'b1;
    end else if (active && !rsp_valid) begin
      lat <= lat + 1'b1;
    end
  end

  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_noack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (lat == LAT));

  p_losign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !c_round) |-> !rsp_r[W-1]);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !(c_a == MINV && c_b == MINV)) |-> !rsp_ovf);

  p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ovf) |-> (rsp_a == MAXV));

  p_loclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && c_round) |-> (rsp_r == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_a) && $stable(rsp_r) && $stable(rsp_ovf)));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready));

endmodule

bind fmul_frac fmul_frac_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_round (req_round),
  .req_a     (req_a),
  .req_b     (req_b),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_a     (rsp_a),
  .rsp_r     (rsp_r),
  .rsp_ovf   (rsp_ovf)
);

// File: tb/sim_fmul_frac.sv
`timescale 1ns/1ps
module sim_fmul_frac;

  localparam int W = 20;

  typedef struct packed {
    logic         md;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] ea;
    logic [W-1:0] er;
    logic         eo;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 20'h40000, 20'h40000, 20'h20000, 20'h00000, 1'b0},
    '{1'b0, 20'hC0000, 20'h40000, 20'hE0000, 20'h00000, 1'b0},
    '{1'b0, 20'h00001, 20'h00001, 20'h00000, 20'h00001, 1'b0},
    '{1'b0, 20'hFFFFF, 20'h00001, 20'hFFFFF, 20'h7FFFF, 1'b0},
    '{1'b0, 20'h80000, 20'h80000, 20'h7FFFF, 20'h7FFFF, 1'b1},
    '{1'b1, 20'h80000, 20'h80000, 20'h7FFFF, 20'h00000, 1'b1},
    '{1'b0, 20'h7FFFF, 20'h7FFFF, 20'h7FFFE, 20'h00001, 1'b0},
    '{1'b1, 20'h7FFFF, 20'h7FFFF, 20'h7FFFE, 20'h00000, 1'b0},
    '{1'b1, 20'h80000, 20'h7FFFF, 20'h80001, 20'h00000, 1'b0},
    '{1'b0, 20'h80000, 20'h7FFFF, 20'h80001, 20'h00000, 1'b0},
    '{1'b1, 20'h00001, 20'h40000, 20'h00001, 20'h00000, 1'b0},
    '{1'b0, 20'h00001, 20'h40000, 20'h00000, 20'h40000, 1'b0},
    '{1'b1, 20'h00001, 20'h3FFFF, 20'h00000, 20'h00000, 1'b0},
    '{1'b1, 20'hFFFFF, 20'h40000, 20'h00000, 20'h00000, 1'b0},
    '{1'b0, 20'hFFFFF, 20'h40000, 20'hFFFFF, 20'h40000, 1'b0},
    '{1'b1, 20'hFFFFF, 20'h40001, 20'hFFFFF, 20'h00000, 1'b0},
    '{1'b0, 20'h80000, 20'h40000, 20'hC0000, 20'h00000, 1'b0},
    '{1'b0, 20'h00000, 20'h80000, 20'h00000, 20'h00000, 1'b0},
    '{1'b0, 20'h12345, 20'h00010, 20'h00002, 20'h23450, 1'b0},
    '{1'b1, 20'h12345, 20'h00010, 20'h00002, 20'h00000, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_round = 1'b0;
  logic [W-1:0] req_a = '0;
  logic [W-1:0] req_b = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [W-1:0] rsp_a;
  logic [W-1:0] rsp_r;
  logic         rsp_ovf;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  fmul_frac #(.W(W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_round (req_round),
    .req_a     (req_a),
    .req_b     (req_b),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_a     (rsp_a),
    .rsp_r     (rsp_r),
    .rsp_ovf   (rsp_ovf)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run = n_run + 1;
    if (got !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Present one request, then wait for rsp_valid at negedges.
  // lat counts edges after the accepting edge.
  task automatic do_op(input logic md, input logic [W-1:0] a, input logic [W-1:0] b,
                       output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_round = md; req_a = a; req_b = b;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic [W-1:0] ha, hr;
    logic ho;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    chk("R8 req_ready", 64'(req_ready), 64'd1);
    chk("R8 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R8 rsp_a",     64'(rsp_a),     64'd0);
    chk("R8 rsp_r",     64'(rsp_r),     64'd0);
    chk("R8 rsp_ovf",   64'(rsp_ovf),   64'd0);

    // Vector table: R3 / R6 values, R4 low sign, R5 overflow, R2 latency
    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].md, VECS[i].a, VECS[i].b, lat);
      chk("R2 latency", 64'(lat), 64'(W));
      if (VECS[i].md) begin
        chk("R6 rounded hi", 64'(rsp_a), 64'(VECS[i].ea));
        chk("R6 lo cleared", 64'(rsp_r), 64'(VECS[i].er));
      end else begin
        chk("R3 hi word", 64'(rsp_a), 64'(VECS[i].ea));
        chk("R3 lo word", 64'(rsp_r), 64'(VECS[i].er));
        chk("R4 lo sign", 64'(rsp_r[W-1]), 64'd0);
      end
      chk("R5 overflow", 64'(rsp_ovf), 64'(VECS[i].eo));
    end

    // R1: inputs changing during a run are ignored
    @(negedge clk);
    req_valid = 1'b1; req_round = 1'b0; req_a = 20'h40000; req_b = 20'h40000;
    @(negedge clk);
    req_a = 20'h7FFFF; req_b = 20'h80000; req_round = 1'b1;
    chk("R1 busy not ready", 64'(req_ready), 64'd0);
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    chk("R1 hi unaffected", 64'(rsp_a), 64'h20000);
    chk("R1 lo unaffected", 64'(rsp_r), 64'h0);
    chk("R1 ovf unaffected", 64'(rsp_ovf), 64'd0);

    // R7: back-pressure holds the result
    @(negedge clk);
    rsp_ready = 1'b0;
    do_op(1'b0, 20'h80000, 20'h80000, lat);
    ha = rsp_a; hr = rsp_r; ho = rsp_ovf;
    chk("R5 hold hi", 64'(ha), 64'h7FFFF);
    repeat (5) @(negedge clk);
    chk("R7 valid held", 64'(rsp_valid), 64'd1);
    chk("R7 not ready while held", 64'(req_ready), 64'd0);
    chk("R7 hi stable", 64'(rsp_a), 64'(ha));
    chk("R7 lo stable", 64'(rsp_r), 64'(hr));
    chk("R7 ovf stable", 64'(rsp_ovf), 64'(ho));
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R7 valid dropped", 64'(rsp_valid), 64'd0);
    chk("R7 ready returned", 64'(req_ready), 64'd1);

    // R6 after R7: rounding still correct on a fresh request
    do_op(1'b1, 20'h00001, 20'h40000, lat);
    chk("R6 half rounds up", 64'(rsp_a), 64'h1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule